// File: doc/BRIEF.md
# Variable-Length Bit-Field Insert/Extract Unit

This block reads or writes one bit field of a 36-bit word. A descriptor gives the field with two numbers. The size S is the number of bits in the field, from 0 to 36. The position P is the number of bits that lie below the field's least-significant bit. In extract mode the unit returns the field shifted down to bit 0, with zeros above it. In insert mode the unit takes the low S bits of a data value and places them in the field of a destination word. All bits of the destination outside the field keep their values.

A field must fit inside one word. When P+S is larger than the word width, the unit raises an error flag and returns the input word as it was. The caller handles address generation, pointer stepping and memory access. The unit accepts one operation on every clock and presents the result, registered, one cycle later.

Top module: `bfu_field_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0 and `field_err` becomes 0 after that edge.
- R2: `result` and `field_err` change only at a rising edge. They show the operation whose inputs were sampled at that edge.
- R3: Extract (`op_insert` = 0) returns `word_in` bits P+S-1..P in `result` bits S-1..0. All higher result bits are 0.
- R4: Insert (`op_insert` = 1) returns `word_in` with bits P+S-1..P replaced by `data_in` bits S-1..0. All other bits equal `word_in`.
- R5: Bits of `data_in` at index S and above have no effect on an insert result.
- R6: An extract with S = 0 returns 0 and `field_err` = 0 when P ≤ 36.
- R7: An insert with S = 0 returns `word_in` unchanged and `field_err` = 0 when P ≤ 36.
- R8: S = 36 with P = 0 selects the whole word. Extract returns `word_in` and insert returns `data_in`.
- R9: When P+S > 36 (the sum taken without overflow), `field_err` = 1 and `result` equals `word_in`. This holds in both modes.
- R10: A field that ends exactly at the top bit (P+S = 36) is legal and gives `field_err` = 0.
- R11: `op_insert` selects the mode: 0 selects extract and 1 selects insert. The same operands give the two distinct results of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_insert | input | 1 | 0 = extract, 1 = insert |
| word_in | input | 36 | Source word (extract) or destination word (insert) |
| data_in | input | 36 | Insert data; its low S bits are used |
| size_in | input | 6 | Field size S in bits (legal 0..36) |
| pos_in | input | 6 | Field position P, the bit index of the field's LSB |
| result | output | 36 | Registered result |
| field_err | output | 1 | Registered flag: the field crossed the word boundary |

## Verification
The bench builds the unit with the default 36-bit word and 6-bit size and position fields. This is the narrowest encoding that can express S = 36. It also lets the bench drive positions and sizes whose sum passes the word width, up to 63 each. With these values the bench can reach the empty field, the full-width field, and fields that end exactly on the top bit or one bit past it. It can also reach S = 0 with P = 36, a legal position that lies just outside the word.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int unsigned BFU_WORD_W = 36;

  typedef enum logic {
    BFU_EXTRACT = 1'b0,
    BFU_INSERT  = 1'b1
  } bfu_op_e;
endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned SIZE_W = 6,
  parameter int unsigned POS_W  = 6
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [POS_W-1:0]  pos,
  output logic [WORD_W-1:0] low_mask,
  output logic [WORD_W-1:0] field_mask,
  output logic              in_range
);
  localparam int unsigned SUM_W = ((SIZE_W > POS_W) ? SIZE_W : POS_W) + 1;

  logic [SUM_W-1:0] field_end;
  assign field_end = SUM_W'(pos) + SUM_W'(size);
  assign in_range  = (field_end <= SUM_W'(WORD_W));

  // Each mask bit is a comparator; no shifter is needed for the masks.
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign low_mask[i]   = (32'(size) > i);
    assign field_mask[i] = (32'(pos) <= i) && (32'(field_end) > i);
  end

  always_comb begin
    // R3: the low mask holds exactly min(S, WORD_W) ones
    assert_low_mask_width_R3 : assert ($countones(low_mask) ==
        ((32'(size) > WORD_W) ? WORD_W : 32'(size)));
  end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned POS_W  = 6
) (
  input  logic [WORD_W-1:0] word,
  input  logic [POS_W-1:0]  pos,
  input  logic [WORD_W-1:0] low_mask,
  output logic [WORD_W-1:0] field
);
  logic [WORD_W-1:0] shifted;
  assign shifted = word >> pos;
  assign field   = shifted & low_mask;
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned POS_W  = 6
) (
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] data,
  input  logic [POS_W-1:0]  pos,
  input  logic [WORD_W-1:0] low_mask,
  input  logic [WORD_W-1:0] field_mask,
  output logic [WORD_W-1:0] merged
);
  logic [WORD_W-1:0] placed;
  assign placed = (data & low_mask) << pos;
  assign merged = (word & ~field_mask) | (placed & field_mask);
endmodule

// File: rtl/bfu_field_unit.sv
module bfu_field_unit
  import bfu_pkg::*;
#(
  parameter int unsigned WORD_W = BFU_WORD_W,
  parameter int unsigned SIZE_W = $clog2(WORD_W + 1),
  parameter int unsigned POS_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_insert,
  input  logic [WORD_W-1:0] word_in,
  input  logic [WORD_W-1:0] data_in,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [POS_W-1:0]  pos_in,
  output logic [WORD_W-1:0] result,
  output logic              field_err
);
  localparam int unsigned SUM_W = ((SIZE_W > POS_W) ? SIZE_W : POS_W) + 1;

  bfu_op_e           op;
  logic [WORD_W-1:0] low_mask;
  logic [WORD_W-1:0] field_mask;
  logic              in_range;
  logic [WORD_W-1:0] ext_val;
  logic [WORD_W-1:0] ins_val;
  logic [WORD_W-1:0] next_result;

  assign op = bfu_op_e'(op_insert);

  bfu_mask_gen #(.WORD_W(WORD_W), .SIZE_W(SIZE_W), .POS_W(POS_W)) u_mask (
    .size      (size_in),
    .pos       (pos_in),
    .low_mask  (low_mask),
    .field_mask(field_mask),
    .in_range  (in_range)
  );

  bfu_extract #(.WORD_W(WORD_W), .POS_W(POS_W)) u_ext (
    .word    (word_in),
    .pos     (pos_in),
    .low_mask(low_mask),
    .field   (ext_val)
  );

  bfu_insert #(.WORD_W(WORD_W), .POS_W(POS_W)) u_ins (
    .word      (word_in),
    .data      (data_in),
    .pos       (pos_in),
    .low_mask  (low_mask),
    .field_mask(field_mask),
    .merged    (ins_val)
  );

  always_comb begin
    if (!in_range)             next_result = word_in;
    else if (op == BFU_INSERT) next_result = ins_val;
    else                       next_result = ext_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      field_err <= 1'b0;
    end else begin
      result    <= next_result;
      field_err <= ~in_range;
    end
  end

  // Marks cycles whose output came from a non-reset edge, so $past is valid.
  logic primed_q;
  always_ff @(posedge clk) begin
    if (rst) primed_q <= 1'b0;
    else     primed_q <= 1'b1;
  end

  assert_err_passthru_R9 : assert property (@(posedge clk) disable iff (rst)
    (primed_q && field_err) |-> (result == $past(word_in)));

  assert_err_flag_R9 : assert property (@(posedge clk) disable iff (rst)
    primed_q |-> (field_err ==
      ((SUM_W'($past(pos_in)) + SUM_W'($past(size_in))) > SUM_W'(WORD_W))));

  assert_extract_zero_fill_R3 : assert property (@(posedge clk) disable iff (rst)
    (primed_q && !field_err && !$past(op_insert)) |->
      ((result >> $past(size_in)) == '0));

  assert_insert_upper_kept_R4 : assert property (@(posedge clk) disable iff (rst)
    (primed_q && !field_err && $past(op_insert)) |->
      (((result ^ $past(word_in)) >>
        (SUM_W'($past(pos_in)) + SUM_W'($past(size_in)))) == '0));

  assert_insert_lower_kept_R4 : assert property (@(posedge clk) disable iff (rst)
    (primed_q && !field_err && $past(op_insert)) |->
      (((result ^ $past(word_in)) << (SUM_W'(WORD_W) - SUM_W'($past(pos_in)))) == '0));

  assert_empty_insert_R7 : assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(op_insert) && ($past(size_in) == '0)) |->
      (result == $past(word_in)));
endmodule

// File: tb/tb_bfu_field_unit.sv
module tb_bfu_field_unit;
  localparam int W  = 36;
  localparam int SW = 6;

  typedef struct packed {
    logic          op;
    logic [W-1:0]  w;
    logic [W-1:0]  d;
    logic [SW-1:0] s;
    logic [SW-1:0] p;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0, 36'hABCDE1234, 36'h0,         6'd8,  6'd4,  4'd3},  // R3
    '{1'b0, 36'h800000001, 36'h0,         6'd1,  6'd35, 4'd10}, // R10
    '{1'b1, 36'h123456789, 36'hFFFFFFFFF, 6'd12, 6'd12, 4'd4},  // R4
    '{1'b1, 36'h0,         36'h5A,        6'd7,  6'd29, 4'd10}, // R10
    '{1'b0, 36'hFFFFFFFFF, 36'h0,         6'd0,  6'd10, 4'd6},  // R6
    '{1'b1, 36'h0F0F0F0F0, 36'hFFFFFFFFF, 6'd0,  6'd3,  4'd7},  // R7
    '{1'b0, 36'h9A5C3E7F1, 36'h0,         6'd36, 6'd0,  4'd8},  // R8
    '{1'b1, 36'h9A5C3E7F1, 36'h2468ACE13, 6'd36, 6'd0,  4'd8},  // R8
    '{1'b0, 36'h123456789, 36'h0,         6'd20, 6'd17, 4'd9},  // R9
    '{1'b1, 36'h123456789, 36'hF,         6'd1,  6'd36, 4'd9},  // R9
    '{1'b1, 36'h123456789, 36'hF,         6'd0,  6'd36, 4'd10}, // R10
    '{1'b0, 36'h123456789, 36'h0,         6'd36, 6'd1,  4'd9},  // R9
    '{1'b1, 36'h000000000, 36'hFFFFFFFF5, 6'd3,  6'd0,  4'd5},  // R5
    '{1'b1, 36'h0ABCD0000, 36'h3C,        6'd5,  6'd0,  4'd11}  // R11
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          op_insert;
  logic [W-1:0]  word_in, data_in;
  logic [SW-1:0] size_in, pos_in;
  logic [W-1:0]  result;
  logic          field_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bfu_field_unit dut (
    .clk(clk), .rst(rst), .op_insert(op_insert), .word_in(word_in),
    .data_in(data_in), .size_in(size_in), .pos_in(pos_in),
    .result(result), .field_err(field_err)
  );

  // Bit-by-bit reference written from the requirements.
  function automatic logic [W:0] model(input logic op, input logic [W-1:0] w,
                                       input logic [W-1:0] d, input int s, input int p);
    logic [W-1:0] r;
    if (p + s > W) return {1'b1, w};
    r = op ? w : '0;
    for (int i = 0; i < W; i++) begin
      if (op) begin
        if (i >= p && i < p + s) r[i] = d[i-p];
      end else if (i < s) begin
        r[i] = w[p+i];
      end
    end
    return {1'b0, r};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp,
                       input logic ae, input logic ee);
    tests++;
    if (act !== exp || ae !== ee) begin
      fails++;
      $display("FAIL %s: result=%h err=%b expected result=%h err=%b", req, act, ae, exp, ee);
    end
  endtask

  task automatic drive(input logic op, input logic [W-1:0] w, input logic [W-1:0] d,
                       input logic [SW-1:0] s, input logic [SW-1:0] p);
    @(negedge clk);
    op_insert = op; word_in = w; data_in = d; size_in = s; pos_in = p;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W:0] e;
    rst = 1'b1; op_insert = 1'b1; word_in = '1; data_in = '1; size_in = 6'd4; pos_in = 6'd4;
    repeat (3) @(negedge clk);
    check("R1", result, '0, field_err, 1'b0);
    rst = 1'b0;

    // Vector table
    for (int k = 0; k < 14; k++) begin
      drive(VECS[k].op, VECS[k].w, VECS[k].d, VECS[k].s, VECS[k].p);
      e = model(VECS[k].op, VECS[k].w, VECS[k].d, int'(VECS[k].s), int'(VECS[k].p));
      check($sformatf("R%0d", VECS[k].req), result, e[W-1:0], field_err, e[W]);
    end

    // Hand-computed directed cases
    drive(1'b0, 36'hABCDE1234, 36'h0, 6'd8, 6'd4);
    check("R3", result, 36'h000000023, field_err, 1'b0);
    drive(1'b1, 36'h0, 36'hFFF, 6'd4, 6'd8);
    check("R5", result, 36'h000000F00, field_err, 1'b0);
    drive(1'b1, 36'hFFFFFFFFF, 36'h0, 6'd36, 6'd0);
    check("R8", result, 36'h0, field_err, 1'b0);
    drive(1'b0, 36'h123456789, 36'h0, 6'd10, 6'd30);
    check("R9", result, 36'h123456789, field_err, 1'b1);
    drive(1'b1, 36'h123456789, 36'h0, 6'd63, 6'd63);
    check("R9", result, 36'h123456789, field_err, 1'b1);
    // R11: same operands, both modes
    drive(1'b0, 36'hF0000000F, 36'h5, 6'd4, 6'd0);
    check("R11", result, 36'h00000000F, field_err, 1'b0);
    drive(1'b1, 36'hF0000000F, 36'h5, 6'd4, 6'd0);
    check("R11", result, 36'hF00000005, field_err, 1'b0);

    // R2: new inputs do not show before the next edge
    @(negedge clk);
    op_insert = 1'b0; word_in = 36'hFFFFFFFFF; size_in = 6'd8; pos_in = 6'd0;
    #1 check("R2", result, 36'hF00000005, field_err, 1'b0);
    @(negedge clk);
    check("R2", result, 36'h0000000FF, field_err, 1'b0);

    // R1: reset during operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, '0, field_err, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule